// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block performs addition, subtraction and bitwise logic on 8-bit or 16-bit operands. It produces the result combinationally in the same cycle. It also keeps a registered status word holding six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. A one-bit width select picks byte or word operation. In byte mode the upper operand bytes are ignored and the upper result byte reads zero.

The status word is loaded from the current operation only on a cycle in which the flag-write enable is high; on every other cycle it holds. Three control bits are kept next to it as plain bits that software writes and the block only stores: single-step trap, interrupt enable and string direction (0 forward, 1 backward).

Top module: `alu_status`

## Requirements
- R1: `op` selects the operation: 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, and 5 to 7 NOT of `a`. With `wide`=0 only `a[7:0]` and `b[7:0]` are used, and `result[15:8]` is 0.
- R2: Carry (`st_flags[0]`) is the carry out of the active width on add and the borrow (a < b unsigned) on subtract. It is 0 for logic operations.
- R3: Auxiliary carry (`st_flags[2]`) is the carry out of bit 3 on add and the borrow into bit 4 on subtract. It is 0 for logic operations.
- R4: Overflow (`st_flags[5]`) is 1 when the signed result falls outside the range of the active width, for example byte 100+50. It is 0 for logic operations.
- R5: Parity (`st_flags[1]`) is 1 when `result[7:0]` holds an even number of ones, in both widths.
- R6: Zero (`st_flags[3]`) is 1 exactly when the active-width result is 0. Sign (`st_flags[4]`) is the result's top bit: bit 7 in byte mode, bit 15 in word mode.
- R7: `st_flags` loads at a rising clock edge only when `flag_we` is 1, holds otherwise, and is cleared by reset (`rst_n` low).
- R8: `ctl_flags` (bit 0 trap, bit 1 interrupt enable, bit 2 direction) loads `ctl_in` at a rising edge when `ctl_we` is 1, holds otherwise, and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation select |
| wide | input | 1 | 1 word, 0 byte |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| flag_we | input | 1 | Load status flags this cycle |
| ctl_we | input | 1 | Load control bits this cycle |
| ctl_in | input | 3 | New control bits |
| result | output | 16 | Operation result |
| st_flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |
| ctl_flags | output | 3 | {direction, interrupt enable, trap} |

## Verification
In byte mode every value of `a` is paired with sixteen `b` values that repeat one nibble (0x00, 0x11 … 0xFF), under each operation. This reaches every low-nibble carry and borrow combination, the unsigned wrap at 255 and the signed wrap at 127/-128, which separates carry, auxiliary carry and overflow from one another. Word mode uses a grid of edge values (0, 1, 0x7FFF, 0x8000, 0xFFFF, 0x00FF, 0x0100 and a few mixed patterns). This shows that carry and sign come from bit 15 while parity still looks only at the low byte. The upper byte of each byte-mode operand is filled with noise to show that it is ignored. Further steps drop `flag_we` and `ctl_we` while the inputs would change the state, and check that the stored bits hold.

// File: rtl/alu_status.sv
module alu_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic         wide,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         flag_we,
  input  logic         ctl_we,
  input  logic [2:0]   ctl_in,
  output logic [W-1:0] result,
  output logic [5:0]   st_flags,
  output logic [2:0]   ctl_flags
);
  localparam int H = W / 2;

  logic [W-1:0] am, bm, lres;
  logic [W:0]   full;
  logic [4:0]   nib;
  logic         is_add, is_sub, arith;
  logic         sa, sb, sr, cy, ov, par, zr;

  assign am     = wide ? a : {{(W-H){1'b0}}, a[H-1:0]};
  assign bm     = wide ? b : {{(W-H){1'b0}}, b[H-1:0]};
  assign is_add = (op == 3'd0);
  assign is_sub = (op == 3'd1);
  assign arith  = is_add | is_sub;

  always_comb begin
    case (op)
      3'd2:    lres = am & bm;
      3'd3:    lres = am | bm;
      3'd4:    lres = am ^ bm;
      default: lres = ~am;
    endcase
    if (is_add) begin
      full = {1'b0, am} + {1'b0, bm};
      nib  = {1'b0, am[3:0]} + {1'b0, bm[3:0]};
    end else if (is_sub) begin
      full = {1'b0, am} - {1'b0, bm};
      nib  = {1'b0, am[3:0]} - {1'b0, bm[3:0]};
    end else begin
      full = {1'b0, lres};
      nib  = '0;
    end
  end

  assign result = wide ? full[W-1:0] : {{(W-H){1'b0}}, full[H-1:0]};
  assign sa  = wide ? am[W-1] : am[H-1];
  assign sb  = wide ? bm[W-1] : bm[H-1];
  assign sr  = wide ? result[W-1] : result[H-1];
  assign cy  = arith & (wide ? full[W] : full[H]);
  assign ov  = (is_add & (sa == sb) & (sr != sa)) | (is_sub & (sa != sb) & (sr != sa));
  assign par = ~^result[7:0];
  assign zr  = (result == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_flags  <= '0;
      ctl_flags <= '0;
    end else begin
      if (flag_we) st_flags <= {ov, sr, zr, nib[4] & arith, par, cy};
      if (ctl_we)  ctl_flags <= ctl_in;
    end
  end
endmodule

module alu_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic        wide,
  input logic        flag_we,
  input logic        ctl_we,
  input logic [2:0]  ctl_in,
  input logic [15:0] result,
  input logic [5:0]  st_flags,
  input logic [2:0]  ctl_flags
);
  assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> result[15:8] == 8'h00);
  assert_logic_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 3'd2) |=> st_flags[0] == 1'b0);
  assert_logic_no_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 3'd2) |=> st_flags[2] == 1'b0);
  assert_logic_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 3'd2) |=> st_flags[5] == 1'b0);
  assert_parity_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> st_flags[1] == ($countones($past(result[7:0])) % 2 == 0));
  assert_zero_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> st_flags[3] == ($past(result) == 16'h0000));
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(st_flags));
  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_flags == $past(ctl_in));
  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_flags));
endmodule

bind alu_status alu_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .flag_we(flag_we),
  .ctl_we(ctl_we), .ctl_in(ctl_in), .result(result),
  .st_flags(st_flags), .ctl_flags(ctl_flags)
);

// File: tb/alu_status_test.sv
`timescale 1ns/100ps
module alu_status_test;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  op = 0, ctl_in = 0;
  logic        wide = 0, flag_we = 0, ctl_we = 0;
  logic [15:0] a = 0, b = 0, result;
  logic [5:0]  st_flags;
  logic [2:0]  ctl_flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_status uut (.clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .a(a), .b(b),
    .flag_we(flag_we), .ctl_we(ctl_we), .ctl_in(ctl_in), .result(result),
    .st_flags(st_flags), .ctl_flags(ctl_flags));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d wide=%0d a=%h b=%h actual=%h expected=%h",
               req, op, wide, a, b, act, exp);
    end
  endtask

  function automatic void model(input int o, input bit w16, input int x, input int y,
                                output int r, output bit [5:0] f);
    int w = w16 ? 16 : 8;
    int m = (1 << w) - 1;
    int xa = x & m, yb = y & m, full = 0, sx, sy, sres, ones = 0;
    bit c = 0, ac = 0, ov = 0;
    case (o)
      0: begin full = xa + yb; c = full > m; ac = ((xa & 15) + (yb & 15)) > 15; end
      1: begin full = xa - yb; c = xa < yb;  ac = (xa & 15) < (yb & 15); end
      2: full = xa & yb;
      3: full = xa | yb;
      4: full = xa ^ yb;
      default: full = ~xa;
    endcase
    r = full & m;
    sx = (xa >= (1 << (w - 1))) ? xa - (1 << w) : xa;
    sy = (yb >= (1 << (w - 1))) ? yb - (1 << w) : yb;
    if (o == 0) sres = sx + sy; else if (o == 1) sres = sx - sy; else sres = 0;
    ov = (sres >= (1 << (w - 1))) || (sres < -(1 << (w - 1)));
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    f = {ov, 1'((r >> (w - 1)) & 1), r == 0, ac, (ones % 2) == 0, c};
  endfunction

  task automatic apply(input int o, input bit w16, input int x, input int y);
    int er;
    bit [5:0] ef;
    op = 3'(o); wide = w16; flag_we = 1;
    a = w16 ? 16'(x) : {8'h5A ^ 8'(x), 8'(x)};
    b = w16 ? 16'(y) : {8'hC3, 8'(y)};
    model(o, w16, x, y, er, ef);
    #1;
    chk("R1 result", result, er);
    @(posedge clk);
    @(negedge clk);
    chk("R2 carry", st_flags[0], ef[0]);
    chk("R5 parity", st_flags[1], ef[1]);
    chk("R3 aux", st_flags[2], ef[2]);
    chk("R6 zero", st_flags[3], ef[3]);
    chk("R6 sign", st_flags[4], ef[4]);
    chk("R4 overflow", st_flags[5], ef[5]);
  endtask

  int wv[12] = '{0, 1, 'h7FFF, 'h8000, 'hFFFF, 'h00FF, 'h0100, 'h0F0F,
                 'h1234, 'hABCD, 'h8001, 'h7FFE};

  initial begin
    #200_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset flags", st_flags, 0);
    chk("R8 reset ctl", ctl_flags, 0);
    rst_n = 1;
    @(negedge clk);
    apply(0, 0, 255, 1);
    apply(0, 0, 100, 50);
    for (int x = 0; x < 256; x++)
      for (int j = 0; j < 16; j++)
        for (int o = 0; o < 6; o++)
          apply(o, 0, x, j * 17);
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 6; o++)
          apply(o, 1, wv[i], wv[j]);
    apply(7, 0, 'h3C, 0);
    apply(6, 1, 'h00FF, 0);
    // R7: flags hold without flag_we
    apply(0, 0, 255, 1);
    flag_we = 0; op = 1; wide = 0; a = 0; b = 1;
    @(posedge clk); @(negedge clk);
    chk("R7 hold", st_flags, 6'b001111);
    // R8: control bits load and hold
    ctl_we = 1; ctl_in = 3'b101;
    @(posedge clk); @(negedge clk);
    chk("R8 load", ctl_flags, 3'b101);
    ctl_in = 3'b010;
    @(posedge clk); @(negedge clk);
    chk("R8 load", ctl_flags, 3'b010);
    ctl_we = 0; ctl_in = 3'b111;
    @(posedge clk); @(negedge clk);
    chk("R8 hold", ctl_flags, 3'b010);
    chk("R7 hold with ctl", st_flags, 6'b001111);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule